// File: doc/BRIEF.md
# Eight-Bit ALU with Selectively Updated Flags

This block is the arithmetic and logic datapath for a small 8-bit register-to-register processor. A two-operand combinational unit produces the result in the same cycle. A five-bit condition register sits beside it and captures carry, zero, sign, overflow and a signed less-than flag on the next rising clock edge.

Each operation writes only its own group of flags. Add, subtract and compare write all five. The bitwise operations and the right shift write zero, sign and less-than, and keep carry and overflow. Increment, decrement and pass-through leave every flag alone, which lets pointer arithmetic run between a compare and the branch that tests it. Compare does not produce a new value: its result port returns the first operand unchanged, and only the flags see the difference.

The surrounding core gives the operation code, both register values and a flag-write strobe. It writes the result back to the register file. It branches on the registered flags.

Top module: `alu8_flags`

## Requirements
- R1: Operation codes are 0 pass, 1 add, 2 subtract, 3 compare, 4 AND, 5 OR, 6 NOT, 7 shift right, 8 increment, 9 decrement. Add gives a+b, subtract gives a-b, increment gives a+1 and decrement gives a-1, all modulo 256, on `res_o` in the same cycle.
- R2: AND gives a&b and OR gives a|b. NOT gives ~a and ignores b. Pass gives b.
- R3: Shift right moves a right by the unsigned amount in b and fills with zeros. An amount of 8 or more gives 0.
- R4: Compare returns a unchanged on `res_o`. Its flags are those of a-b.
- R5: For add, C is the carry out of bit 7. For subtract and compare, C is set when a < b unsigned (borrow).
- R6: For every flag-writing operation, Z is set when the 8-bit value is zero and S equals its bit 7. For compare, that value is the difference.
- R7: For add, subtract and compare, O marks two's-complement overflow and L equals S XOR O.
- R8: AND, OR, NOT and shift right write Z, S and L, with L equal to S. C and O keep their previous values.
- R9: Pass, increment, decrement and the unused codes 10 to 15 change no flag. The unused codes give a result of 0.
- R10: While `flag_we` is low, no flag changes, whatever the operation.
- R11: A synchronous active-high reset clears all five flags on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opd_a | input | 8 | First operand (destination register value) |
| opd_b | input | 8 | Second operand / shift amount |
| op_sel | input | 4 | Operation code |
| flag_we | input | 1 | Flag write strobe |
| res_o | output | 8 | Combinational result |
| flag_c | output | 1 | Registered carry / borrow |
| flag_z | output | 1 | Registered zero |
| flag_s | output | 1 | Registered sign |
| flag_o | output | 1 | Registered signed overflow |
| flag_l | output | 1 | Registered signed less-than |

## Verification
The hardest situation to observe is partial flag update. A bitwise operation or a shift must keep C and O at values left by an earlier arithmetic operation, and increment or decrement must keep all five. That can only be seen if an earlier operation has first set C and O to values that the current one would otherwise change.

The vector table is walked in a fixed order for this reason. Carry-producing and overflow-producing arithmetic steps come directly before the bitwise, shift, increment and decrement steps. Every expected flag word was worked out from that history. Separate directed steps then hold the strobe low during a flag-changing add, and pulse reset in the middle of the run.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W  = 4;
  localparam int FLG_N = 5;

  typedef enum logic [OP_W-1:0] {
    OP_PASS = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_CMP  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_NOT  = 4'd6,
    OP_SHR  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic o;
    logic l;
  } flags_t;

  function automatic logic is_arith(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
  endfunction

  function automatic logic is_logic(input alu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_NOT) || (op == OP_SHR);
  endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         ovf
);
  logic         do_sub;
  logic [W-1:0] rhs;
  logic [W-1:0] rhs_x;
  logic [W:0]   sum;

  always_comb begin
    do_sub = (op == OP_SUB) || (op == OP_CMP) || (op == OP_DEC);
    if ((op == OP_INC) || (op == OP_DEC)) rhs = W'(1);
    else                                  rhs = b;
    rhs_x = rhs ^ {W{do_sub}};
    sum   = {1'b0, a} + {1'b0, rhs_x} + {{W{1'b0}}, do_sub};
    res   = sum[W-1:0];
    carry = do_sub ? ~sum[W] : sum[W];
    ovf   = (a[W-1] == rhs_x[W-1]) && (res[W-1] != a[W-1]);
  end

  logic [W-1:0] back_sum;
  assign back_sum = res + b;

  always_comb begin
    // R1
    if (op == OP_SUB) sub_inverse_chk: assert (back_sum == a);
    // R5
    if (op == OP_ADD) add_wrap_chk: assert (carry == (res < a));
    // R5
    if (op == OP_CMP) cmp_borrow_chk: assert (carry == (a < b));
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] res
);
  logic [W-1:0] shr_v;

  always_comb begin
    if (b >= W[W-1:0] || b >= W) shr_v = '0;
    else                         shr_v = a >> b;
  end

  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_NOT:  res = ~a;
      OP_SHR:  res = shr_v;
      OP_PASS: res = b;
      default: res = '0;
    endcase
  end

  always_comb begin
    // R3
    if (op == OP_SHR) shr_bits_chk: assert ($countones(res) <= $countones(a));
    // R2
    if (op == OP_AND) and_subset_chk: assert ((res & ~a) == '0 && (res & ~b) == '0);
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
  import alu8_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  flags_t upd,
  input  flags_t nxt,
  output flags_t q
);
  logic [FLG_N-1:0] upd_v, nxt_v, q_v;

  assign upd_v = upd;
  assign nxt_v = nxt;
  assign q     = q_v;

  for (genvar i = 0; i < FLG_N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           q_v[i] <= 1'b0;
      else if (upd_v[i]) q_v[i] <= nxt_v[i];
    end
  end

  // R11
  rst_clear_chk: assert property (@(posedge clk) $past(rst) |-> (q_v == '0));
  // R8
  c_keep_chk: assert property (@(posedge clk) disable iff (rst) $past(!upd.c) |-> $stable(q.c));
  // R8
  o_keep_chk: assert property (@(posedge clk) disable iff (rst) $past(!upd.o) |-> $stable(q.o));
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opd_a,
  input  logic [W-1:0] opd_b,
  input  logic [3:0]   op_sel,
  input  logic         flag_we,
  output logic [W-1:0] res_o,
  output logic         flag_c,
  output logic         flag_z,
  output logic         flag_s,
  output logic         flag_o,
  output logic         flag_l
);
  alu_op_e      op;
  logic [W-1:0] ar_res, lg_res, flag_src;
  logic         ar_c, ar_o, arith_op, logic_op;
  flags_t       upd, nxt, q;

  assign op = alu_op_e'(op_sel);

  alu8_arith #(.W(W)) u_arith (
    .a(opd_a), .b(opd_b), .op(op), .res(ar_res), .carry(ar_c), .ovf(ar_o)
  );

  alu8_logic #(.W(W)) u_logic (
    .a(opd_a), .b(opd_b), .op(op), .res(lg_res)
  );

  always_comb begin
    arith_op = is_arith(op);
    logic_op = is_logic(op);
    case (op)
      OP_ADD, OP_SUB, OP_INC, OP_DEC: res_o = ar_res;
      OP_CMP:                         res_o = opd_a;
      default:                        res_o = lg_res;
    endcase
    flag_src = arith_op ? ar_res : lg_res;
    nxt.c = ar_c;
    nxt.o = ar_o;
    nxt.z = (flag_src == '0);
    nxt.s = flag_src[W-1];
    nxt.l = arith_op ? (flag_src[W-1] ^ ar_o) : flag_src[W-1];
    upd.c = flag_we && arith_op;
    upd.o = flag_we && arith_op;
    upd.z = flag_we && (arith_op || logic_op);
    upd.s = flag_we && (arith_op || logic_op);
    upd.l = flag_we && (arith_op || logic_op);
  end

  alu8_flagreg u_flags (
    .clk(clk), .rst(rst), .upd(upd), .nxt(nxt), .q(q)
  );

  assign flag_c = q.c;
  assign flag_z = q.z;
  assign flag_s = q.s;
  assign flag_o = q.o;
  assign flag_l = q.l;

  // R9
  noflag_ops_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!is_arith(op) && !is_logic(op)) |-> $stable(q));
  // R10
  we_low_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!flag_we) |-> $stable(q));
  // R7
  l_rule_chk: assert property (@(posedge clk) disable iff (rst)
    $past(flag_we && is_arith(op)) |-> (q.l == (q.s ^ q.o)));
  // R8
  l_logic_chk: assert property (@(posedge clk) disable iff (rst)
    $past(flag_we && is_logic(op)) |-> (q.l == q.s));
endmodule

// File: tb/sim_alu8_flags.sv
module sim_alu8_flags;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a = '0, b = '0;
  logic [3:0] op = '0;
  logic       we = 1'b0;
  logic [7:0] res;
  logic       fc, fz, fs, fo, fl;
  int         n_chk = 0, n_bad = 0;
  logic       done = 1'b0;

  always #10 clk = ~clk;

  alu8_flags u0 (
    .clk(clk), .rst(rst), .opd_a(a), .opd_b(b), .op_sel(op), .flag_we(we),
    .res_o(res), .flag_c(fc), .flag_z(fz), .flag_s(fs), .flag_o(fo), .flag_l(fl)
  );

  // {op, a, b, expected result, expected flags C Z S O L after the edge}
  localparam int NV = 16;
  localparam logic [32:0] VEC [NV] = '{
    {4'd1, 8'h7F, 8'h01, 8'h80, 5'b00110},
    {4'd1, 8'hFF, 8'h01, 8'h00, 5'b11000},
    {4'd4, 8'hF0, 8'h0F, 8'h00, 5'b11000},
    {4'd5, 8'h80, 8'h01, 8'h81, 5'b10101},
    {4'd2, 8'h80, 8'h01, 8'h7F, 5'b00011},
    {4'd6, 8'h0F, 8'h55, 8'hF0, 5'b00111},
    {4'd8, 8'h7F, 8'h00, 8'h80, 5'b00111},
    {4'd9, 8'h00, 8'h00, 8'hFF, 5'b00111},
    {4'd3, 8'h05, 8'h05, 8'h05, 5'b01000},
    {4'd7, 8'h80, 8'h07, 8'h01, 5'b00000},
    {4'd2, 8'h01, 8'h02, 8'hFF, 5'b10101},
    {4'd7, 8'hFF, 8'h08, 8'h00, 5'b11000},
    {4'd0, 8'h12, 8'h34, 8'h34, 5'b11000},
    {4'd3, 8'h03, 8'h80, 8'h03, 5'b10110},
    {4'd7, 8'h81, 8'h00, 8'h81, 5'b10111},
    {4'd15, 8'h11, 8'h22, 8'h00, 5'b10111}
  };

  function automatic string res_tag(input logic [3:0] o);
    case (o)
      4'd1, 4'd2, 4'd8, 4'd9: return "R1";
      4'd0, 4'd4, 4'd5, 4'd6: return "R2";
      4'd7: return "R3";
      4'd3: return "R4";
      default: return "R9";
    endcase
  endfunction

  function automatic string flg_tag(input logic [3:0] o);
    case (o)
      4'd1, 4'd2, 4'd3: return "R5 R6 R7";
      4'd4, 4'd5, 4'd6, 4'd7: return "R8 R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                      input logic w);
    @(negedge clk);
    op = o; a = x; b = y; we = w;
    #1;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    // R11 reset state
    check("R11 reset", {3'b0, fc, fz, fs, fo, fl}, 8'h00);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][32:29], VEC[i][28:21], VEC[i][20:13], 1'b1);
      check(res_tag(VEC[i][32:29]), res, VEC[i][12:5]);
      @(posedge clk);
      #1;
      check(flg_tag(VEC[i][32:29]), {3'b0, fc, fz, fs, fo, fl}, {3'b0, VEC[i][4:0]});
    end

    // R10: strobe low during a carry-producing add, flags stay 10111
    step(4'd1, 8'hFF, 8'h01, 1'b0);
    check("R1 add with strobe low", res, 8'h00);
    @(posedge clk);
    #1;
    check("R10", {3'b0, fc, fz, fs, fo, fl}, 8'b000_10111);

    // R3: shift by a large amount
    step(4'd7, 8'hFF, 8'hC8, 1'b1);
    check("R3 shift 200", res, 8'h00);
    step(4'd7, 8'hB4, 8'h02, 1'b1);
    check("R3 shift 2", res, 8'h2D);
    @(posedge clk);
    #1;
    // R8: C,O kept at 1,1; Z0 S0 L0
    check("R8", {3'b0, fc, fz, fs, fo, fl}, 8'b000_10010);

    // R11: mid-run synchronous reset
    @(negedge clk);
    rst = 1'b1; we = 1'b0;
    @(posedge clk);
    #1;
    check("R11 mid-run", {3'b0, fc, fz, fs, fo, fl}, 8'h00);
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule